// File: doc/BRIEF.md
# Page Access Permission Evaluator

This block decides whether one memory access may go ahead on a page whose translation is already known. It takes the protection bits of the segment descriptor, the protection fields of the page table entry, the kind of access (load, store or instruction fetch), the problem-state flag, and the two per-key authority masks (data and instruction). From these it computes the read/write/execute rights of the page, a grant or deny verdict, and the flags that describe why an instruction or data fault was raised.

Three sources of rights are evaluated independently and then ANDed. The first is a decode of the three page-protection bits under the selected storage key. The second is the no-execute/guarded attribute of the entry. The third is the per-key authority masks, indexed by the entry's key number. A translation pipeline feeds one request per cycle with `in_valid`. The inputs are captured at the clock edge, and the verdict appears in the following cycle, marked by `out_valid`. A translation unit uses the fault flags to build its fault status word.

Top module: `perm_eval`

## Requirements
- R1: A request presented with `in_valid` high at a rising edge produces `out_valid` high for exactly the following cycle. `out_valid` is low after any edge at which `in_valid` was low, and it is low after reset.
- R2: The storage key is `seg_key_user` when `problem_state` is 1 and `seg_key_super` when it is 0.
- R3: The page code is `pp = {pte_pp_hi, pte_pp[1:0]}`, and `perm_rwx` is encoded as bit 2 = read, bit 1 = write, bit 0 = execute. With key 0, codes 0, 1 and 2 give 3'b111, codes 3 and 6 give 3'b101, and the other codes give 3'b000. With key 1, code 2 gives 3'b111, codes 1 and 3 give 3'b101, and the other codes give 3'b000.
- R4: When `pte_no_exec` or `pte_guarded` is set, execute is removed from `perm_rwx`, and read and write are left unchanged.
- R5: When `key_prot_en` is 1, the data authority field for key k is the bit pair `amr[2*(2**KEY_BITS-1-k) +: 2]`. Its upper bit removes write and its lower bit removes read. When `key_prot_en` is 0, the `amr` bits have no effect.
- R6: When both `key_prot_en` and `iamr_en` are 1, the lower bit of the same pair in `iamr` removes execute. Otherwise `iamr` has no effect.
- R7: `perm_rwx` is the AND of the rights from R3, R4, R5 and R6. The needed right is read for a load (`access` 0), write for a store (`access` 1) and execute for a fetch (`access` 2). Code 3 is treated as a load. `granted` is 1 exactly when the needed right is present, except in the case covered by R10.
- R8: On a denied fetch, `ifault_noexec` is set if R4 removed execute. Otherwise `ifault_prot` is set if R3 removed execute. Independently of these, `ifault_iamr` is set if R6 removed execute. All data flags are 0.
- R9: On a denied load or store, `dfault_prot` is set if R3 lacks the needed right, `dfault_store` is set for a store, and `dfault_amr` is set if R5 lacks the needed right. All fetch flags are 0. On a granted access, all six flags are 0.
- R10: A fetch with `seg_no_exec` set is denied with only `ifault_noexec` set, whatever the page rights are. `perm_rwx` still reports the page rights.
- R11: While `out_valid` is 0, `perm_rwx`, `granted` and all fault flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| access | input | 2 | 0 load, 1 store, 2 fetch, 3 treated as load |
| problem_state | input | 1 | 1 when the access is made in user state |
| seg_key_user | input | 1 | Segment key used in user state |
| seg_key_super | input | 1 | Segment key used in supervisor state |
| seg_no_exec | input | 1 | Segment forbids instruction fetch |
| pte_pp_hi | input | 1 | Upper bit of the page code |
| pte_pp | input | 2 | Lower two bits of the page code |
| pte_no_exec | input | 1 | Entry no-execute attribute |
| pte_guarded | input | 1 | Entry guarded attribute |
| pte_key | input | KEY_BITS | Authority key number of the entry |
| amr | input | 2*2**KEY_BITS | Data authority mask, two bits per key |
| iamr | input | 2*2**KEY_BITS | Instruction authority mask, two bits per key |
| key_prot_en | input | 1 | Enables key-based authority checks |
| iamr_en | input | 1 | Enables the instruction authority check |
| out_valid | output | 1 | Result strobe |
| perm_rwx | output | 3 | Combined rights {R,W,X} |
| granted | output | 1 | Access allowed |
| ifault_noexec | output | 1 | Fetch fault: no-execute or guarded |
| ifault_prot | output | 1 | Fetch fault: page code |
| ifault_iamr | output | 1 | Fetch fault: instruction authority mask |
| dfault_prot | output | 1 | Data fault: page code |
| dfault_store | output | 1 | Data fault on a store |
| dfault_amr | output | 1 | Data fault: data authority mask |

## Verification
The sweep covers every page code under both keys in both privilege states, all four access codes, every combination of the attribute and enable bits, and every authority pair. The key number rotates through all slots, and the slots that are not selected are filled with the opposite pattern. With this fill, a design that reads the mirrored slot or swaps the two bits of a pair grants or denies the wrong accesses. Fetches that combine a guarded page, a pp denial and an instruction-mask denial catch a priority that reports both the guard and pp causes, or that drops the independent mask flag. Idle cycles are inserted between requests to catch a result that leaks while `out_valid` is low. Segment no-execute cases catch a design that lets page flags show through.

// File: rtl/perm_eval_pkg.sv
package perm_eval_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam logic [2:0] RT_R    = 3'b100;
  localparam logic [2:0] RT_W    = 3'b010;
  localparam logic [2:0] RT_X    = 3'b001;
  localparam logic [2:0] RT_ALL  = 3'b111;
  localparam logic [2:0] RT_RX   = 3'b101;
  localparam logic [2:0] RT_NONE = 3'b000;

  // Rights granted by the three-bit page code under one storage key.
  function automatic logic [2:0] pp_rights(input logic key, input logic [2:0] pp);
    logic [2:0] r;
    r = RT_NONE;
    if (!key) begin
      case (pp)
        3'd0, 3'd1, 3'd2: r = RT_ALL;
        3'd3, 3'd6:       r = RT_RX;
        default:          r = RT_NONE;
      endcase
    end else begin
      case (pp)
        3'd2:       r = RT_ALL;
        3'd1, 3'd3: r = RT_RX;
        default:    r = RT_NONE;
      endcase
    end
    return r;
  endfunction

  // One-hot right demanded by an access kind.
  function automatic logic [2:0] needed_right(input logic [1:0] acc);
    logic [2:0] n;
    case (acc)
      ACC_STORE: n = RT_W;
      ACC_FETCH: n = RT_X;
      default:   n = RT_R;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/perm_pp_decode.sv
module perm_pp_decode (
  input  logic       problem_state,
  input  logic       key_user,
  input  logic       key_super,
  input  logic [2:0] pp,
  output logic       key_sel,
  output logic [2:0] rights
);
  import perm_eval_pkg::*;

  always_comb begin
    key_sel = problem_state ? key_user : key_super;
    rights  = pp_rights(key_sel, pp);
  end
endmodule

// File: rtl/perm_key_mask.sv
module perm_key_mask #(
  parameter int KEY_BITS = 5,
  localparam int NUM_KEYS = 1 << KEY_BITS,
  localparam int MASK_W   = 2 * NUM_KEYS
) (
  input  logic [KEY_BITS-1:0] key_num,
  input  logic [MASK_W-1:0]   data_mask,
  input  logic [MASK_W-1:0]   inst_mask,
  input  logic                key_prot_en,
  input  logic                inst_en,
  output logic [1:0]          data_pair,
  output logic                inst_bit,
  output logic [2:0]          rights
);
  localparam logic [KEY_BITS-1:0] LAST_SLOT = KEY_BITS'(NUM_KEYS - 1);

  logic [KEY_BITS-1:0] slot;
  logic [KEY_BITS:0]   base;

  always_comb begin
    // key 0 lives in the most significant pair
    slot      = LAST_SLOT - key_num;
    base      = {slot, 1'b0};
    data_pair = data_mask[base +: 2];
    inst_bit  = inst_mask[base];
    rights    = 3'b111;
    if (key_prot_en) begin
      rights[2] = ~data_pair[0];
      rights[1] = ~data_pair[1];
      rights[0] = inst_en ? ~inst_bit : 1'b1;
    end
  end
endmodule

// File: rtl/perm_fault_prio.sv
module perm_fault_prio (
  input  logic [1:0] acc,
  input  logic       seg_no_exec,
  input  logic [2:0] pp_rights_m,
  input  logic [2:0] attr_rights,
  input  logic [2:0] key_rights,
  output logic [2:0] final_rights,
  output logic       allow,
  output logic       f_inx,
  output logic       f_iprot,
  output logic       f_iamr,
  output logic       f_dprot,
  output logic       f_dstore,
  output logic       f_damr
);
  import perm_eval_pkg::*;

  logic [2:0] need;
  logic       is_fetch;
  logic       seg_block;

  always_comb begin
    need         = needed_right(acc);
    is_fetch     = (acc == ACC_FETCH);
    seg_block    = is_fetch && seg_no_exec;
    final_rights = pp_rights_m & attr_rights & key_rights;
    allow        = !seg_block && ((need & final_rights) != 3'b000);
    f_inx    = 1'b0;
    f_iprot  = 1'b0;
    f_iamr   = 1'b0;
    f_dprot  = 1'b0;
    f_dstore = 1'b0;
    f_damr   = 1'b0;
    if (seg_block) begin
      f_inx = 1'b1;
    end else if (!allow && is_fetch) begin
      if (!attr_rights[0])      f_inx   = 1'b1;
      else if (!pp_rights_m[0]) f_iprot = 1'b1;
      f_iamr = ~key_rights[0];
    end else if (!allow) begin
      f_dprot  = (need & ~pp_rights_m) != 3'b000;
      f_dstore = (acc == ACC_STORE);
      f_damr   = (need & ~key_rights) != 3'b000;
    end
  end
endmodule

// File: rtl/perm_eval.sv
module perm_eval #(
  parameter int KEY_BITS = 5,
  localparam int MASK_W = 2 << KEY_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          access,
  input  logic                problem_state,
  input  logic                seg_key_user,
  input  logic                seg_key_super,
  input  logic                seg_no_exec,
  input  logic                pte_pp_hi,
  input  logic [1:0]          pte_pp,
  input  logic                pte_no_exec,
  input  logic                pte_guarded,
  input  logic [KEY_BITS-1:0] pte_key,
  input  logic [MASK_W-1:0]   amr,
  input  logic [MASK_W-1:0]   iamr,
  input  logic                key_prot_en,
  input  logic                iamr_en,
  output logic                out_valid,
  output logic [2:0]          perm_rwx,
  output logic                granted,
  output logic                ifault_noexec,
  output logic                ifault_prot,
  output logic                ifault_iamr,
  output logic                dfault_prot,
  output logic                dfault_store,
  output logic                dfault_amr
);
  // captured request
  logic                vld_q;
  logic [1:0]          acc_q;
  logic                pr_q, kuser_q, ksup_q, segnx_q;
  logic [2:0]          pp_q;
  logic                nx_q, grd_q;
  logic [KEY_BITS-1:0] key_q;
  logic [MASK_W-1:0]   amr_q, iamr_q;
  logic                kprot_q, ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      acc_q   <= 2'd0;
      pr_q    <= 1'b0;
      kuser_q <= 1'b0;
      ksup_q  <= 1'b0;
      segnx_q <= 1'b0;
      pp_q    <= 3'd0;
      nx_q    <= 1'b0;
      grd_q   <= 1'b0;
      key_q   <= '0;
      amr_q   <= '0;
      iamr_q  <= '0;
      kprot_q <= 1'b0;
      ien_q   <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        acc_q   <= access;
        pr_q    <= problem_state;
        kuser_q <= seg_key_user;
        ksup_q  <= seg_key_super;
        segnx_q <= seg_no_exec;
        pp_q    <= {pte_pp_hi, pte_pp};
        nx_q    <= pte_no_exec;
        grd_q   <= pte_guarded;
        key_q   <= pte_key;
        amr_q   <= amr;
        iamr_q  <= iamr;
        kprot_q <= key_prot_en;
        ien_q   <= iamr_en;
      end
    end
  end

  // named internal events, observed by the checker
  logic       key_sel;
  logic [2:0] pp_mask;
  logic [2:0] attr_mask;
  logic [2:0] key_mask;
  logic [1:0] amr_pair;
  logic       iamr_bit;
  logic [2:0] final_mask;
  logic       allow;
  logic       f_inx, f_iprot, f_iamr, f_dprot, f_dstore, f_damr;

  assign attr_mask = {2'b11, ~(nx_q | grd_q)};

  perm_pp_decode u_pp (
    .problem_state (pr_q),
    .key_user      (kuser_q),
    .key_super     (ksup_q),
    .pp            (pp_q),
    .key_sel       (key_sel),
    .rights        (pp_mask)
  );

  perm_key_mask #(.KEY_BITS(KEY_BITS)) u_key (
    .key_num     (key_q),
    .data_mask   (amr_q),
    .inst_mask   (iamr_q),
    .key_prot_en (kprot_q),
    .inst_en     (ien_q),
    .data_pair   (amr_pair),
    .inst_bit    (iamr_bit),
    .rights      (key_mask)
  );

  perm_fault_prio u_prio (
    .acc          (acc_q),
    .seg_no_exec  (segnx_q),
    .pp_rights_m  (pp_mask),
    .attr_rights  (attr_mask),
    .key_rights   (key_mask),
    .final_rights (final_mask),
    .allow        (allow),
    .f_inx        (f_inx),
    .f_iprot      (f_iprot),
    .f_iamr       (f_iamr),
    .f_dprot      (f_dprot),
    .f_dstore     (f_dstore),
    .f_damr       (f_damr)
  );

  always_comb begin
    out_valid     = vld_q;
    perm_rwx      = vld_q ? final_mask : 3'b000;
    granted       = vld_q & allow;
    ifault_noexec = vld_q & f_inx;
    ifault_prot   = vld_q & f_iprot;
    ifault_iamr   = vld_q & f_iamr;
    dfault_prot   = vld_q & f_dprot;
    dfault_store  = vld_q & f_dstore;
    dfault_amr    = vld_q & f_damr;
  end
endmodule

// File: rtl/perm_eval_checker.sv
module perm_eval_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       out_valid,
  input logic [2:0] perm_rwx,
  input logic       granted,
  input logic       ifault_noexec,
  input logic       ifault_prot,
  input logic       ifault_iamr,
  input logic       dfault_prot,
  input logic       dfault_store,
  input logic       dfault_amr,
  input logic [1:0] acc_q,
  input logic       kprot_q,
  input logic [2:0] key_mask
);
  import perm_eval_pkg::*;

  logic [5:0] flags;
  assign flags = {ifault_noexec, ifault_prot, ifault_iamr, dfault_prot, dfault_store, dfault_amr};

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R1
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> (perm_rwx == 3'b000 && !granted && flags == 6'd0)); // R11
  AST_KEYS_OFF: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !kprot_q) |-> key_mask == 3'b111); // R5
  AST_DENY_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !granted) |-> flags != 6'd0); // R7
  AST_FETCH_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({ifault_noexec, ifault_prot})); // R8
  AST_FETCH_NO_DFLAGS: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && acc_q == ACC_FETCH) |-> flags[2:0] == 3'b000); // R8
  AST_DATA_NO_IFLAGS: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && acc_q != ACC_FETCH) |-> flags[5:3] == 3'b000); // R9
  AST_GRANT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) granted |-> flags == 6'd0); // R9
  AST_STORE_TAG: assert property (@(posedge clk) disable iff (!rst_n) dfault_store |-> acc_q == ACC_STORE); // R9
endmodule

bind perm_eval perm_eval_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .out_valid     (out_valid),
  .perm_rwx      (perm_rwx),
  .granted       (granted),
  .ifault_noexec (ifault_noexec),
  .ifault_prot   (ifault_prot),
  .ifault_iamr   (ifault_iamr),
  .dfault_prot   (dfault_prot),
  .dfault_store  (dfault_store),
  .dfault_amr    (dfault_amr),
  .acc_q         (acc_q),
  .kprot_q       (kprot_q),
  .key_mask      (key_mask)
);

// File: tb/tb_perm_eval.sv
`timescale 1ns/1ps
module tb_perm_eval;
  localparam int KB = 5;
  localparam int MW = 2 << KB;
  localparam real HALF = 10.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] access = 2'd0;
  logic problem_state = 1'b0, seg_key_user = 1'b0, seg_key_super = 1'b0, seg_no_exec = 1'b0;
  logic pte_pp_hi = 1'b0, pte_no_exec = 1'b0, pte_guarded = 1'b0;
  logic [1:0] pte_pp = 2'd0;
  logic [KB-1:0] pte_key = '0;
  logic [MW-1:0] amr = '0, iamr = '0;
  logic key_prot_en = 1'b0, iamr_en = 1'b0;
  logic out_valid, granted;
  logic [2:0] perm_rwx;
  logic ifault_noexec, ifault_prot, ifault_iamr, dfault_prot, dfault_store, dfault_amr;

  int vectors = 0;
  int misses = 0;

  always #(HALF) clk = ~clk;

  perm_eval #(.KEY_BITS(KB)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .access(access),
    .problem_state(problem_state), .seg_key_user(seg_key_user),
    .seg_key_super(seg_key_super), .seg_no_exec(seg_no_exec),
    .pte_pp_hi(pte_pp_hi), .pte_pp(pte_pp), .pte_no_exec(pte_no_exec),
    .pte_guarded(pte_guarded), .pte_key(pte_key), .amr(amr), .iamr(iamr),
    .key_prot_en(key_prot_en), .iamr_en(iamr_en), .out_valid(out_valid),
    .perm_rwx(perm_rwx), .granted(granted), .ifault_noexec(ifault_noexec),
    .ifault_prot(ifault_prot), .ifault_iamr(ifault_iamr),
    .dfault_prot(dfault_prot), .dfault_store(dfault_store), .dfault_amr(dfault_amr)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // page code rights, written as arithmetic on the code value
  function automatic int code_rights(input int key, input int pp);
    if (key == 0) return (pp <= 2) ? 7 : ((pp == 3 || pp == 6) ? 5 : 0);
    return (pp == 2) ? 7 : ((pp == 1 || pp == 3) ? 5 : 0);
  endfunction

  initial begin
    #(HALF * 2 * 300000);
    misses++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1, R11: reset state
    check("R1 reset valid", {7'd0, out_valid}, 8'd0);
    check("R11 reset outputs", {perm_rwx, granted, ifault_noexec, ifault_prot, ifault_iamr, dfault_prot},
          8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle after reset", {out_valid, perm_rwx, granted, dfault_store, dfault_amr, ifault_iamr}, 8'd0);

    for (int idx = 0; idx < 65536; idx++) begin
      int acc, pr, ku, ks, sn, pp, nx, gd, af, ib, kpe, ien, key, sel, shamt;
      int prr, atr, kr, fin, need, is_f;
      logic [7:0] e_main, e_flags;
      acc = idx & 3;          pr = (idx >> 2) & 1;   ku = (idx >> 3) & 1;
      ks = (idx >> 4) & 1;    sn = (idx >> 5) & 1;   pp = (idx >> 6) & 7;
      nx = (idx >> 9) & 1;    gd = (idx >> 10) & 1;  af = (idx >> 11) & 3;
      ib = (idx >> 13) & 1;   kpe = (idx >> 14) & 1; ien = (idx >> 15) & 1;
      key = (idx * 7 + (idx >> 6)) % 32;
      shamt = 2 * (31 - key);

      access = acc[1:0]; problem_state = pr[0]; seg_key_user = ku[0];
      seg_key_super = ks[0]; seg_no_exec = sn[0];
      {pte_pp_hi, pte_pp} = pp[2:0]; pte_no_exec = nx[0]; pte_guarded = gd[0];
      pte_key = key[KB-1:0]; key_prot_en = kpe[0]; iamr_en = ien[0];
      amr = {32{~af[1:0]}};
      amr = (amr & ~(64'h3 << shamt)) | (64'(af) << shamt);
      iamr = {32{{1'b0, ~ib[0]}}};
      iamr = (iamr & ~(64'h3 << shamt)) | (64'(ib) << shamt);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;

      // expected, from the requirements
      sel = pr ? ku : ks;                              // R2
      prr = code_rights(sel, pp);                      // R3
      atr = (nx | gd) ? 6 : 7;                         // R4
      kr = 7;
      if (kpe == 1) begin                              // R5, R6
        if (af & 1) kr = kr - 4;
        if (af & 2) kr = kr - 2;
        if (ien == 1 && ib == 1) kr = kr - 1;
      end
      fin = prr & atr & kr;                            // R7
      need = (acc == 1) ? 2 : ((acc == 2) ? 1 : 4);
      is_f = (acc == 2);
      e_flags = 8'd0;
      e_main = {4'd0, fin[2:0], 1'b0};
      if (is_f && sn == 1) begin                       // R10
        e_flags[5] = 1'b1;
      end else if ((need & fin) != 0) begin
        e_main[0] = 1'b1;
      end else if (is_f) begin                         // R8
        if ((atr & 1) == 0) e_flags[5] = 1'b1;
        else if ((prr & 1) == 0) e_flags[4] = 1'b1;
        e_flags[3] = ((kr & 1) == 0);
      end else begin                                   // R9
        e_flags[2] = ((need & ~prr) != 0);
        e_flags[1] = (acc == 1);
        e_flags[0] = ((need & ~kr) != 0);
      end

      check("R1 valid strobe", {7'd0, out_valid}, 8'd1);
      check((is_f && sn == 1) ? "R10 segment fetch" : "R2 R3 R4 R5 R6 R7 rights/verdict",
            {4'd0, perm_rwx, granted}, e_main);
      check(is_f ? "R8 R10 fetch flags" : "R9 data flags",
            {2'd0, ifault_noexec, ifault_prot, ifault_iamr, dfault_prot, dfault_store, dfault_amr}, e_flags);

      if ((idx & 4095) == 4095) begin
        @(negedge clk);
        check("R11 idle quiet", {out_valid, perm_rwx, granted, ifault_noexec, ifault_iamr, dfault_prot}, 8'd0);
        check("R1 no strobe", {7'd0, out_valid}, 8'd0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule